// File: doc/BRIEF.md
# Binary Trie Longest-Prefix Lookup Engine

This engine finds the longest stored prefix that matches a destination key. It does this by walking a binary trie held in an on-chip node memory. Each node carries three things: a next-hop value that counts only when a prefix terminates at that node, a left-child index and a right-child index. A prefix is never stored explicitly. Its value is implied by the path from the root to its node.

Before any lookup, software-side logic preloads the trie through a dedicated write port, one whole node per write. A lookup is then requested with a start pulse and a key. The engine reads one node per memory access, with one wait state per level for the synchronous memory. It steers on successive key bits from the most significant bit down, and it remembers the next hop of the deepest prefix node it has passed. The walk ends when the selected child index is the null value 0, or when all key bits are used up. At that point the engine pulses done and presents the remembered next hop together with a found flag.

Top module: `trie_lpm_engine`

## Requirements
- R1: After reset, ready is 1, and done, found and next_hop are all 0.
- R2: A start pulse is accepted only while ready is 1, and the key is captured on that edge. Ready is 0 from the next cycle until the lookup completes. A start pulse seen while ready is 0 is ignored: it does not alter the result, the timing, or start a further lookup.
- R3: The walk begins at node index 1 and treats index 0 as null. At the node reached after d key bits (the root has d = 0), key bit KEY_W-1-d selects the child: 0 follows the left-child index, 1 follows the right-child index.
- R4: When any node on the path has its prefix-valid field set, done comes with found = 1 and next_hop equal to the next-hop field of the deepest such node.
- R5: When no node on the path has its prefix-valid field set, done comes with found = 0 and next_hop = 0.
- R6: The walk ends at the first node whose selected child is null. A node reached after all KEY_W bits ends the walk without its child indices being followed, so one lookup makes at most KEY_W+1 node reads.
- R7: Done is high for exactly one cycle. It rises 2n clock edges after the accepting edge, where n is the number of nodes read. Ready is 1 again in the cycle after done.
- R8: Found and next_hop keep their values from done until the next accepted start.
- R9: A prefix-valid root acts as a default route. It is reported when no deeper prefix matches, and it is replaced by any deeper match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Lookup request, accepted while ready is 1 |
| key | input | KEY_W | Destination key, most significant bit used first |
| ready | output | 1 | Engine idle and able to accept start |
| wr_en | input | 1 | Node memory write strobe |
| wr_addr | input | PTR_W | Node index to write |
| wr_valid | input | 1 | Prefix-valid field of the written node |
| wr_next_hop | input | NH_W | Next-hop field of the written node |
| wr_left | input | PTR_W | Left-child index of the written node (0 = null) |
| wr_right | input | PTR_W | Right-child index of the written node (0 = null) |
| done | output | 1 | One-cycle lookup completion pulse |
| found | output | 1 | A prefix matched on the path |
| next_hop | output | NH_W | Next hop of the longest matching prefix, 0 when none |

## Verification
The bench builds the engine with KEY_W = 5, PTR_W = 4 and NH_W = 4. A short key lets a small hand-built trie reach the full depth limit, including a node at depth KEY_W that has non-null children the engine must not follow. The four-prefix example fits in sixteen nodes, so every node can be cleared and the expected path, node count and done latency of each key can be worked out by hand. That setting covers null-terminated walks at the root, mid-path and at a leaf, walks that see no prefix at all, a default route at the root, and a start pulse arriving mid-walk.

// File: rtl/trie_pkg.sv
`timescale 1ns/1ps
package trie_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EVAL = 2'd2,
    ST_DONE = 2'd3
  } walk_state_t;

endpackage

// File: rtl/trie_node_mem.sv
`timescale 1ns/1ps
module trie_node_mem #(
  parameter int PTR_W  = 8,
  parameter int WORD_W = 25
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  localparam int DEPTH = 1 << PTR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= mem_q[rd_addr];
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/trie_key_shift.sv
`timescale 1ns/1ps
module trie_key_shift #(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [KEY_W-1:0] key_in,
  output logic             key_bit
);

  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] key_d;
  logic             key_en;

  always_comb begin
    key_en = load | shift;
    key_d  = key_q;
    if (load) begin
      key_d = key_in;
    end else if (shift) begin
      key_d = {key_q[KEY_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
    end else if (key_en) begin
      key_q <= key_d;
    end
  end

  assign key_bit = key_q[KEY_W-1];

endmodule

// File: rtl/trie_walk_ctrl.sv
`timescale 1ns/1ps
module trie_walk_ctrl
  import trie_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int PTR_W = 8,
  parameter int NH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             key_bit,
  input  logic             node_valid,
  input  logic [NH_W-1:0]  node_nh,
  input  logic [PTR_W-1:0] node_left,
  input  logic [PTR_W-1:0] node_right,
  output logic             rd_en,
  output logic [PTR_W-1:0] rd_addr,
  output logic             key_load,
  output logic             key_shift,
  output logic             ready,
  output logic             done,
  output logic             found,
  output logic [NH_W-1:0]  next_hop
);

  localparam int DEP_W = $clog2(KEY_W + 1);
  localparam logic [DEP_W-1:0] DEP_LAST = DEP_W'(KEY_W);
  localparam logic [PTR_W-1:0] ROOT_IDX = PTR_W'(1);
  localparam logic [PTR_W-1:0] NULL_IDX = '0;

  walk_state_t      state_q, state_d;
  logic [PTR_W-1:0] idx_q, idx_d;
  logic [DEP_W-1:0] depth_q, depth_d;
  logic             found_q, found_d;
  logic [NH_W-1:0]  nh_q, nh_d;
  logic             walk_en;
  logic             best_en;
  logic [PTR_W-1:0] child;
  logic             at_limit;

  assign child    = key_bit ? node_right : node_left;
  assign at_limit = (depth_q == DEP_LAST);

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    depth_d   = depth_q;
    found_d   = found_q;
    nh_d      = nh_q;
    walk_en   = 1'b0;
    best_en   = 1'b0;
    rd_en     = 1'b0;
    key_load  = 1'b0;
    key_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_READ;
          idx_d    = ROOT_IDX;
          depth_d  = '0;
          found_d  = 1'b0;
          nh_d     = '0;
          walk_en  = 1'b1;
          best_en  = 1'b1;
          key_load = 1'b1;
        end
      end
      ST_READ: begin
        rd_en   = 1'b1;
        state_d = ST_EVAL;
      end
      ST_EVAL: begin
        if (node_valid) begin
          found_d = 1'b1;
          nh_d    = node_nh;
          best_en = 1'b1;
        end
        if (at_limit || (child == NULL_IDX)) begin
          state_d = ST_DONE;
        end else begin
          state_d   = ST_READ;
          idx_d     = child;
          depth_d   = depth_q + DEP_W'(1);
          walk_en   = 1'b1;
          key_shift = 1'b1;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      depth_q <= '0;
    end else if (walk_en) begin
      idx_q   <= idx_d;
      depth_q <= depth_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      nh_q    <= '0;
    end else if (best_en) begin
      found_q <= found_d;
      nh_q    <= nh_d;
    end
  end

  assign rd_addr  = idx_q;
  assign ready    = (state_q == ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign found    = found_q;
  assign next_hop = nh_q;

endmodule

// File: rtl/trie_lpm_engine.sv
`timescale 1ns/1ps
module trie_lpm_engine #(
  parameter int KEY_W = 32,
  parameter int PTR_W = 8,
  parameter int NH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] key,
  output logic             ready,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic             wr_valid,
  input  logic [NH_W-1:0]  wr_next_hop,
  input  logic [PTR_W-1:0] wr_left,
  input  logic [PTR_W-1:0] wr_right,
  output logic             done,
  output logic             found,
  output logic [NH_W-1:0]  next_hop
);

  localparam int WORD_W = 1 + NH_W + 2 * PTR_W;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic              mem_rd_en;
  logic [PTR_W-1:0]  mem_rd_addr;
  logic              key_load;
  logic              key_shift;
  logic              key_bit;
  logic              node_valid;
  logic [NH_W-1:0]   node_nh;
  logic [PTR_W-1:0]  node_left;
  logic [PTR_W-1:0]  node_right;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  assign wr_word = {wr_valid, wr_next_hop, wr_left, wr_right};
  assign {node_valid, node_nh, node_left, node_right} = rd_word;

  trie_node_mem #(
    .PTR_W (PTR_W),
    .WORD_W(WORD_W)
  ) u_mem (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_word),
    .rd_en  (mem_rd_en),
    .rd_addr(mem_rd_addr),
    .rd_data(rd_word)
  );

  trie_key_shift #(
    .KEY_W(KEY_W)
  ) u_key (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (key_load),
    .shift  (key_shift),
    .key_in (key),
    .key_bit(key_bit)
  );

  trie_walk_ctrl #(
    .KEY_W(KEY_W),
    .PTR_W(PTR_W),
    .NH_W (NH_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .key_bit   (key_bit),
    .node_valid(node_valid),
    .node_nh   (node_nh),
    .node_left (node_left),
    .node_right(node_right),
    .rd_en     (mem_rd_en),
    .rd_addr   (mem_rd_addr),
    .key_load  (key_load),
    .key_shift (key_shift),
    .ready     (ready),
    .done      (done),
    .found     (found),
    .next_hop  (next_hop)
  );

endmodule

// File: rtl/trie_lpm_engine_chk.sv
`timescale 1ns/1ps
module trie_lpm_engine_chk #(
  parameter int KEY_W = 32,
  parameter int PTR_W = 8,
  parameter int NH_W  = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             start,
  input logic             ready,
  input logic             done,
  input logic             found,
  input logic [NH_W-1:0]  next_hop,
  input logic             mem_rd_en,
  input logic [PTR_W-1:0] mem_rd_addr
);

  localparam int CNT_W = $clog2(KEY_W + 3);
  localparam logic [CNT_W-1:0] READ_MAX = CNT_W'(KEY_W + 1);

  logic [CNT_W-1:0] rd_cnt_q;
  logic             accept;

  assign accept = start && ready;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_cnt_q <= '0;
    end else if (accept) begin
      rd_cnt_q <= '0;
    end else if (mem_rd_en && (rd_cnt_q <= READ_MAX)) begin
      rd_cnt_q <= rd_cnt_q + CNT_W'(1);
    end
  end

  AST_FIRST_READ_ROOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |=> (mem_rd_en && (mem_rd_addr == PTR_W'(1)))); // R3

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |=> !ready); // R2

  AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready |-> !mem_rd_en); // R2

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> (!done && ready)); // R7

  AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ready && !start) |=> ($stable(found) && $stable(next_hop))); // R8

  AST_READ_BUDGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_rd_en |-> (rd_cnt_q < READ_MAX)); // R6

  AST_MISS_ZERO_HOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !found) |-> (next_hop == '0)); // R5

endmodule

bind trie_lpm_engine trie_lpm_engine_chk #(
  .KEY_W(KEY_W),
  .PTR_W(PTR_W),
  .NH_W (NH_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .start      (start),
  .ready      (ready),
  .done       (done),
  .found      (found),
  .next_hop   (next_hop),
  .mem_rd_en  (mem_rd_en),
  .mem_rd_addr(mem_rd_addr)
);

// File: tb/trie_lpm_engine_tb.sv
`timescale 1ns/1ps
module trie_lpm_engine_tb;

  localparam int KEY_W = 5;
  localparam int PTR_W = 4;
  localparam int NH_W  = 4;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [KEY_W-1:0] key;
  logic             ready;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr;
  logic             wr_valid;
  logic [NH_W-1:0]  wr_next_hop;
  logic [PTR_W-1:0] wr_left;
  logic [PTR_W-1:0] wr_right;
  logic             done;
  logic             found;
  logic [NH_W-1:0]  next_hop;

  int n_checks;
  int n_fails;

  trie_lpm_engine #(.KEY_W(KEY_W), .PTR_W(PTR_W), .NH_W(NH_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .ready(ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_valid(wr_valid),
    .wr_next_hop(wr_next_hop), .wr_left(wr_left), .wr_right(wr_right),
    .done(done), .found(found), .next_hop(next_hop)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic write_node(input int idx, input bit v, input int nh, input int l, input int r);
    @(negedge clk);
    wr_en       = 1'b1;
    wr_addr     = PTR_W'(idx);
    wr_valid    = v;
    wr_next_hop = NH_W'(nh);
    wr_left     = PTR_W'(l);
    wr_right    = PTR_W'(r);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One lookup; checks latency (R7), busy (R2), found and next hop.
  task automatic lookup(input string req, input logic [KEY_W-1:0] k, input bit exp_found,
                        input int exp_nh, input int exp_nodes, input bit poke);
    int cyc;
    @(negedge clk);
    start = 1'b1;
    key   = k;
    @(posedge clk);
    cyc = 0;
    forever begin
      @(negedge clk);
      if (cyc == 0) begin
        start = 1'b0;
        check("R2", "ready after accept", int'(ready), 0);
      end
      if (poke && cyc == 1) begin
        start = 1'b1;
        key   = ~k;
      end
      if (poke && cyc == 2) begin
        start = 1'b0;
      end
      if (done) break;
      cyc++;
      if (cyc > 200) break;
    end
    check("R7", "done edges", cyc, 2 * exp_nodes);
    check(req, "found", int'(found), int'(exp_found));
    check(req, "next_hop", int'(next_hop), exp_nh);
    @(negedge clk);
    check("R7", "done single cycle", int'(done), 0);
    check("R7", "ready after done", int'(ready), 1);
  endtask

  task automatic t_reset();
    check("R1", "ready", int'(ready), 1);
    check("R1", "done", int'(done), 0);
    check("R1", "found", int'(found), 0);
    check("R1", "next_hop", int'(next_hop), 0);
  endtask

  task automatic t_load_trie();
    for (int i = 0; i < (1 << PTR_W); i++) write_node(i, 1'b0, 0, 0, 0);
    write_node(1, 1'b0, 0,     0, 2);
    write_node(2, 1'b0, 0,     3, 4);
    write_node(3, 1'b1, 4'h5,  0, 5);
    write_node(4, 1'b0, 0,     0, 6);
    write_node(5, 1'b0, 0,     7, 0);
    write_node(6, 1'b1, 4'hA,  0, 0);
    write_node(7, 1'b1, 4'hC,  0, 8);
    write_node(8, 1'b1, 4'h3,  2, 2);
  endtask

  task automatic t_example();
    lookup("R4", 5'b10111, 1'b1, 4'h5, 4, 1'b0);
  endtask

  task automatic t_steering();
    lookup("R3", 5'b10100, 1'b1, 4'hC, 5, 1'b0);
    lookup("R3", 5'b11100, 1'b1, 4'hA, 4, 1'b0);
  endtask

  task automatic t_no_prefix();
    lookup("R5", 5'b11010, 1'b0, 0, 3, 1'b0);
    lookup("R5", 5'b01101, 1'b0, 0, 1, 1'b0);
  endtask

  task automatic t_depth_limit();
    lookup("R6", 5'b10101, 1'b1, 4'h3, 6, 1'b0);
  endtask

  task automatic t_busy_start();
    lookup("R2", 5'b10111, 1'b1, 4'h5, 4, 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R2", "no extra lookup done", int'(done), 0);
    end
    check("R2", "result unchanged", int'(next_hop), 4'h5);
  endtask

  task automatic t_hold();
    lookup("R8", 5'b11100, 1'b1, 4'hA, 4, 1'b0);
    write_node(6, 1'b1, 4'h7, 0, 0);
    repeat (4) @(negedge clk);
    check("R8", "found held", int'(found), 1);
    check("R8", "next_hop held", int'(next_hop), 4'hA);
    lookup("R8", 5'b11100, 1'b1, 4'h7, 4, 1'b0);
  endtask

  task automatic t_default_route();
    write_node(1, 1'b1, 4'h9, 0, 2);
    lookup("R9", 5'b01101, 1'b1, 4'h9, 1, 1'b0);
    lookup("R9", 5'b11010, 1'b1, 4'h9, 3, 1'b0);
    lookup("R9", 5'b10111, 1'b1, 4'h5, 4, 1'b0);
  endtask

  initial begin
    n_checks    = 0;
    n_fails     = 0;
    rst_n       = 1'b0;
    start       = 1'b0;
    key         = '0;
    wr_en       = 1'b0;
    wr_addr     = '0;
    wr_valid    = 1'b0;
    wr_next_hop = '0;
    wr_left     = '0;
    wr_right    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_trie();
    t_example();
    t_steering();
    t_no_prefix();
    t_depth_limit();
    t_busy_start();
    t_hold();
    t_default_route();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule